// File: doc/BRIEF.md
# Immediate-Offset Store Execution Unit

This block executes one store-register-with-immediate instruction of a 64-bit instruction set at a time. An instruction word is accepted on a valid strobe while the unit is idle. The unit decodes the word into one of three addressing forms: post-index, pre-index or scaled unsigned offset. It fetches the base and data registers through a combinational register-file read port. Register number 31 in the base field selects the stack pointer.

When the instruction is legal and allowed to proceed, the unit issues one memory write request carrying the address, lane-aligned data, byte strobes and a size code, and holds it until the memory side accepts it. The base register update, when the form requires one, goes to the general register file or to the stack pointer in the cycle after the handshake. A done pulse follows that update. Illegal words, a misaligned stack pointer and a base/data register clash are reported with the done pulse. A 2-bit policy input selects how the unit handles the clash.

Top module: `istore_unit`

## Requirements
- R1: A word is legal only when bit 31 is 1, [29:27]=3'b111, [26]=0 and [23:22]=2'b00, and one of two forms holds. The indexed forms need [25:24]=2'b00, [21]=0 and [10]=1, with [11]=0 for post-index and [11]=1 for pre-index. The unsigned form needs [25:24]=2'b01. Any other word raises `illegal` with the done pulse, and produces no memory request and no writeback.
- R2: Post-index (9-bit signed immediate in [20:12]) stores to the unmodified base. It then writes base plus the sign-extended immediate back to register Rn ([9:5]).
- R3: Pre-index stores to base plus the sign-extended 9-bit immediate and writes that same address back to Rn.
- R4: The unsigned form stores to base plus the 12-bit immediate [21:10] zero-extended and shifted left by the size field, and performs no writeback.
- R5: Size [31:30]=2'b11 is a 64-bit store with `mem_size`=2'b11 and base strobe 8'hFF. Size 2'b10 is a 32-bit store with `mem_size`=2'b10, base strobe 8'h0F, and only the low 32 bits of Rt ([4:0]). Strobes are shifted left by address[2:0] bytes and data by 8*address[2:0] bits, truncated to 8 lanes.
- R6: When Rn is 31, the base is read from `sp_val` and writeback uses `sp_we`/`sp_wdata`. `rf_we` is never raised in that case.
- R7: When Rn is 31 and `sp_val[3:0]` is nonzero, `align_fault` is raised with the done pulse, with no memory request and no writeback.
- R8: For an indexed form with Rn equal to Rt and Rn not 31, `overlap_policy` decides the outcome. 2'b00 stores the register value. 2'b01 stores zero. 2'b10 raises `undef_trap` with no side effects. 2'b11 completes with no side effects and no flag. The unsigned form ignores the policy.
- R9: `tag_checked` is presented with the done pulse. It is high when the word is legal and either the form writes back or Rn is not 31.
- R10: While `mem_req_valid` is high and `mem_req_ready` low, the request fields stay unchanged and valid stays high.
- R11: Writeback strobes appear in the cycle after the handshake edge, and `done` in the cycle after that. For illegal, faulting, trapping or skipped words, `done` appears two cycles after the accepting edge. After reset no request, writeback or done is active.
- R12: `instr_valid` is ignored unless the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 32 | Instruction word |
| overlap_policy | input | 2 | Base/data clash policy |
| rf_base_idx | output | 5 | Base register read index |
| rf_base_val | input | 64 | Base register read value |
| rf_data_idx | output | 5 | Data register read index |
| rf_data_val | input | 64 | Data register read value |
| sp_val | input | 64 | Current stack pointer |
| mem_req_valid | output | 1 | Store request valid |
| mem_req_ready | input | 1 | Store request accepted |
| mem_addr | output | 64 | Store byte address |
| mem_wdata | output | 64 | Lane-aligned store data |
| mem_wstrb | output | 8 | Byte strobes |
| mem_size | output | 2 | Size code (2'b10 word, 2'b11 doubleword) |
| rf_we | output | 1 | General register writeback enable |
| rf_waddr | output | 5 | Writeback register index |
| rf_wdata | output | 64 | Writeback value |
| sp_we | output | 1 | Stack pointer writeback enable |
| sp_wdata | output | 64 | Stack pointer writeback value |
| done | output | 1 | Instruction completed |
| illegal | output | 1 | Illegal encoding (with done) |
| align_fault | output | 1 | Stack pointer misaligned (with done) |
| undef_trap | output | 1 | Clash policy trap (with done) |
| tag_checked | output | 1 | Access is tag checked (with done) |

## Verification
After the accepting edge, the unit spends one cycle in decode. The store request is visible from the second cycle and stays up for as many cycles as the memory side stalls. Writeback comes exactly one cycle after the handshake and done one cycle after that. When no store is made, done comes two cycles after acceptance. The scoreboard monitor samples on falling edges, counts rising edges, and stamps the handshake, writeback and done events with that cycle count. It then compares each event's field values, and the distances between the events, against the expected item. Stalls of zero to several cycles and a stray instruction strobe during a stall exercise the hold and idle-only acceptance rules.

// File: rtl/istore_pkg.sv
package istore_pkg;
  localparam int XLEN    = 64;
  localparam int STRB_W  = XLEN / 8;
  localparam int LANE_AW = $clog2(STRB_W);
  localparam int REG_AW  = 5;
  localparam int SPA_W   = 4;
  localparam int IW      = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXEC, ST_REQ, ST_WB, ST_DONE
  } st_e;

  typedef enum logic [1:0] {
    OVL_KEEP = 2'b00,
    OVL_ZERO = 2'b01,
    OVL_TRAP = 2'b10,
    OVL_SKIP = 2'b11
  } ovl_e;
endpackage

// File: rtl/istore_decode.sv
module istore_decode
  import istore_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int AW = REG_AW
) (
  input  logic [IW-1:0] word,
  output logic          legal,
  output logic          wback,
  output logic          post,
  output logic [1:0]    size,
  output logic [AW-1:0] rn,
  output logic [AW-1:0] rt,
  output logic [W-1:0]  offset
);
  logic fixed_ok, uns_form, idx_form;

  always_comb begin
    fixed_ok = word[31] && (word[29:27] == 3'b111) && !word[26] && (word[23:22] == 2'b00);
    uns_form = (word[25:24] == 2'b01);
    idx_form = (word[25:24] == 2'b00) && !word[21] && word[10];
    legal    = fixed_ok && (uns_form || idx_form);
    wback    = idx_form && !uns_form;
    post     = wback && !word[11];
    size     = word[31:30];
    rn       = word[9:5];
    rt       = word[4:0];
    if (uns_form)
      offset = {{(W-12){1'b0}}, word[21:10]} << size;
    else
      offset = {{(W-9){word[20]}}, word[20:12]};
  end
endmodule

// File: rtl/istore_agen.sv
module istore_agen #(
  parameter int W = istore_pkg::XLEN
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] offset,
  input  logic         post,
  output logic [W-1:0] acc_addr,
  output logic [W-1:0] upd_addr
);
  always_comb begin
    upd_addr = base + offset;
    acc_addr = post ? base : upd_addr;
  end
endmodule

// File: rtl/istore_lane.sv
module istore_lane #(
  parameter int W = istore_pkg::XLEN,
  localparam int SW = W / 8,
  localparam int LW = $clog2(SW)
) (
  input  logic [LW-1:0] lo,
  input  logic [1:0]    size,
  input  logic [W-1:0]  data,
  output logic [W-1:0]  wdata,
  output logic [SW-1:0] wstrb
);
  logic [SW-1:0] mask;
  logic [W-1:0]  kept;

  always_comb begin
    for (int i = 0; i < SW; i++) begin
      mask[i]          = (i < (1 << size));
      kept[8*i +: 8]   = mask[i] ? data[8*i +: 8] : 8'h00;
    end
    wstrb = mask << lo;
    wdata = kept << {lo, 3'b000};
  end
endmodule

// File: rtl/istore_unit.sv
module istore_unit
  import istore_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [IW-1:0]     instr_word,
  input  logic [1:0]        overlap_policy,
  output logic [REG_AW-1:0] rf_base_idx,
  input  logic [XLEN-1:0]   rf_base_val,
  output logic [REG_AW-1:0] rf_data_idx,
  input  logic [XLEN-1:0]   rf_data_val,
  input  logic [XLEN-1:0]   sp_val,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  output logic [STRB_W-1:0] mem_wstrb,
  output logic [1:0]        mem_size,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              sp_we,
  output logic [XLEN-1:0]   sp_wdata,
  output logic              done,
  output logic              illegal,
  output logic              align_fault,
  output logic              undef_trap,
  output logic              tag_checked
);
  localparam logic [REG_AW-1:0] SP_IDX = '1;

  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  st_e state_q, state_d;
  logic [IW-1:0] word_q;
  logic          accept, exec_en;

  logic              d_legal, d_wback, d_post;
  logic [1:0]        d_size;
  logic [REG_AW-1:0] d_rn, d_rt;
  logic [XLEN-1:0]   d_off;

  istore_decode u_dec (
    .word(word_q), .legal(d_legal), .wback(d_wback), .post(d_post),
    .size(d_size), .rn(d_rn), .rt(d_rt), .offset(d_off)
  );

  logic            is_sp, sp_bad, clash, blocked, go_store;
  logic [XLEN-1:0] base, store_src, acc_addr, upd_addr, lane_data;
  logic [STRB_W-1:0] lane_strb;

  always_comb begin
    is_sp     = (d_rn == SP_IDX);
    base      = is_sp ? sp_val : rf_base_val;
    sp_bad    = is_sp && (sp_val[SPA_W-1:0] != '0);
    clash     = d_wback && (d_rn == d_rt) && !is_sp;
    blocked   = clash && (overlap_policy == OVL_TRAP || overlap_policy == OVL_SKIP);
    go_store  = d_legal && !sp_bad && !blocked;
    store_src = (clash && overlap_policy == OVL_ZERO) ? '0 : rf_data_val;
  end

  istore_agen u_agen (
    .base(base), .offset(d_off), .post(d_post),
    .acc_addr(acc_addr), .upd_addr(upd_addr)
  );

  istore_lane u_lane (
    .lo(acc_addr[LANE_AW-1:0]), .size(d_size), .data(store_src),
    .wdata(lane_data), .wstrb(lane_strb)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (instr_valid) state_d = ST_EXEC;
      ST_EXEC: state_d = go_store ? ST_REQ : ST_DONE;
      ST_REQ:  if (mem_req_ready) state_d = ST_WB;
      ST_WB:   state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign accept  = (state_q == ST_IDLE) && instr_valid;
  assign exec_en = (state_q == ST_EXEC);

  logic [XLEN-1:0]   addr_q, wdata_q, wbv_q;
  logic [STRB_W-1:0] strb_q;
  logic [1:0]        size_q;
  logic [REG_AW-1:0] wbi_q;
  logic              wrf_q, wsp_q, ill_q, flt_q, trap_q, tag_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (accept) word_q <= instr_word;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0; wdata_q <= '0; strb_q <= '0; size_q <= '0;
      wbi_q  <= '0; wbv_q   <= '0; wrf_q  <= 1'b0; wsp_q <= 1'b0;
      ill_q  <= 1'b0; flt_q <= 1'b0; trap_q <= 1'b0; tag_q <= 1'b0;
    end else if (exec_en) begin
      addr_q  <= acc_addr;
      wdata_q <= lane_data;
      strb_q  <= lane_strb;
      size_q  <= d_size;
      wbi_q   <= d_rn;
      wbv_q   <= upd_addr;
      wrf_q   <= go_store && d_wback && !is_sp;
      wsp_q   <= go_store && d_wback && is_sp;
      ill_q   <= !d_legal;
      flt_q   <= d_legal && sp_bad;
      trap_q  <= d_legal && !sp_bad && clash && (overlap_policy == OVL_TRAP);
      tag_q   <= d_legal && (d_wback || !is_sp);
    end
  end

  assign rf_base_idx   = d_rn;
  assign rf_data_idx   = d_rt;
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_addr      = addr_q;
  assign mem_wdata     = wdata_q;
  assign mem_wstrb     = strb_q;
  assign mem_size      = size_q;
  assign rf_we         = (state_q == ST_WB) && wrf_q;
  assign sp_we         = (state_q == ST_WB) && wsp_q;
  assign rf_waddr      = wbi_q;
  assign rf_wdata      = wbv_q;
  assign sp_wdata      = wbv_q;
  assign done          = (state_q == ST_DONE);
  assign illegal       = done && ill_q;
  assign align_fault   = done && flt_q;
  assign undef_trap    = done && trap_q;
  assign tag_checked   = done && tag_q;
endmodule

// File: rtl/istore_chk.sv
module istore_chk
  import istore_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [XLEN-1:0]   mem_addr,
  input logic [XLEN-1:0]   mem_wdata,
  input logic [STRB_W-1:0] mem_wstrb,
  input logic [1:0]        mem_size,
  input logic              rf_we,
  input logic [REG_AW-1:0] rf_waddr,
  input logic              sp_we,
  input logic              done,
  input logic              illegal,
  input logic              align_fault,
  input logic              undef_trap
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) &&
      $stable(mem_wdata) && $stable(mem_wstrb) && $stable(mem_size));

  // R11
  wb_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || sp_we) |-> $past(mem_req_valid && mem_req_ready));

  // R11
  done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |-> ##2 done);

  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && sp_we));

  // R6
  sp_not_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != '1));

  // R1
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal, align_fault, undef_trap}));

  // R7
  flag_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal || align_fault || undef_trap) |-> done && !mem_req_valid && !rf_we && !sp_we);

  // R5
  word_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && (mem_size == 2'b10) |-> ($countones(mem_wstrb) <= 4));
endmodule

bind istore_unit istore_chk u_chk (.*);

// File: tb/istore_unit_bench.sv
module istore_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [1:0]  overlap_policy = 2'b00;
  logic [4:0]  rf_base_idx, rf_data_idx, rf_waddr;
  logic [63:0] rf_base_val, rf_data_val, mem_addr, mem_wdata, rf_wdata, sp_wdata;
  logic [63:0] sp_val = '0;
  logic        mem_req_valid, rf_we, sp_we, done, illegal, align_fault, undef_trap, tag_checked;
  logic        mem_req_ready = 1'b0;
  logic [7:0]  mem_wstrb;
  logic [1:0]  mem_size;

  always #2.5 clk = ~clk;

  function automatic logic [63:0] regval(input logic [4:0] i);
    return {32'hC0DE_0000 | 32'(i), 32'h0010_0000 + 32'(i) * 32'h40};
  endfunction

  assign rf_base_val = regval(rf_base_idx);
  assign rf_data_val = regval(rf_data_idx);

  istore_unit u_istore_unit (.*);

  typedef struct {
    bit mem; logic [63:0] addr, data; logic [7:0] strb; logic [1:0] size;
    bit wrf, wsp; logic [4:0] widx; logic [63:0] wval;
    bit ill, flt, trap, tag; string req;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0, cyc = 0, acc_cyc = 0, hs_cyc = 0, stall_left = 0;
  bit seen_mem = 0, seen_wb = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ready driver: stalls for stall_left cycles then accepts
  always begin
    @(posedge clk); #1;
    if (mem_req_valid) begin
      if (stall_left > 0) begin mem_req_ready = 1'b0; stall_left--; end
      else mem_req_ready = 1'b1;
    end else mem_req_ready = 1'b0;
  end

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (mem_req_valid && mem_req_ready) begin
      if (q.size() == 0) chk(0, "R12", "unexpected request", mem_addr, 0);
      else begin
        chk(q[0].mem, q[0].req, "request issued", 1, {63'b0, q[0].mem});
        chk(mem_addr == q[0].addr, q[0].req, "mem_addr", mem_addr, q[0].addr);
        chk(mem_wdata == q[0].data, q[0].req, "mem_wdata", mem_wdata, q[0].data);
        chk(mem_wstrb == q[0].strb, "R5", "mem_wstrb", {56'b0, mem_wstrb}, {56'b0, q[0].strb});
        chk(mem_size == q[0].size, "R5", "mem_size", {62'b0, mem_size}, {62'b0, q[0].size});
      end
      seen_mem = 1; hs_cyc = cyc;
    end
    if (rf_we || sp_we) begin
      seen_wb = 1;
      chk(cyc == hs_cyc + 1, "R11", "writeback cycle", 64'(cyc), 64'(hs_cyc + 1));
      if (q.size() != 0) begin
        chk(rf_we == q[0].wrf && sp_we == q[0].wsp, "R6", "writeback target",
            {62'b0, rf_we, sp_we}, {62'b0, q[0].wrf, q[0].wsp});
        if (rf_we) begin
          chk(rf_waddr == q[0].widx, q[0].req, "rf_waddr", 64'(rf_waddr), 64'(q[0].widx));
          chk(rf_wdata == q[0].wval, q[0].req, "rf_wdata", rf_wdata, q[0].wval);
        end else
          chk(sp_wdata == q[0].wval, "R6", "sp_wdata", sp_wdata, q[0].wval);
      end
    end
    if (done) begin
      if (q.size() == 0) chk(0, "R12", "unexpected done", 1, 0);
      else begin
        chk(seen_mem == q[0].mem, q[0].req, "request count", 64'(seen_mem), 64'(q[0].mem));
        chk(seen_wb == (q[0].wrf || q[0].wsp), q[0].req, "writeback count",
            64'(seen_wb), 64'(q[0].wrf || q[0].wsp));
        chk({illegal, align_fault, undef_trap} == {q[0].ill, q[0].flt, q[0].trap}, q[0].req,
            "flags ill/flt/trap", {61'b0, illegal, align_fault, undef_trap},
            {61'b0, q[0].ill, q[0].flt, q[0].trap});
        chk(tag_checked == q[0].tag, "R9", "tag_checked", 64'(tag_checked), 64'(q[0].tag));
        if (q[0].mem) chk(cyc == hs_cyc + 2, "R11", "done after handshake", 64'(cyc), 64'(hs_cyc + 2));
        else          chk(cyc == acc_cyc + 2, "R11", "done without store", 64'(cyc), 64'(acc_cyc + 2));
        void'(q.pop_front());
      end
      seen_mem = 0; seen_wb = 0;
    end
  end

  task automatic run(input logic [31:0] w, input exp_t e, input logic [1:0] pol,
                     input logic [63:0] spv, input int stall, input bit intrude);
    @(negedge clk);
    overlap_policy = pol; sp_val = spv; stall_left = stall;
    q.push_back(e);
    instr_word = w; instr_valid = 1'b1; acc_cyc = cyc;
    @(negedge clk);
    instr_valid = 1'b0;
    if (intrude) begin
      while (!(mem_req_valid && !mem_req_ready)) @(negedge clk);
      instr_word = {2'b11, 3'b111, 1'b0, 2'b01, 2'b00, 12'd1, 5'd2, 5'd3};
      instr_valid = 1'b1;  // R12: must be ignored while busy
      @(negedge clk);
      instr_valid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_store(input bit uns, input bit pre, input logic [1:0] sz,
                          input logic [11:0] imm, input logic [4:0] rn, input logic [4:0] rt,
                          input logic [1:0] pol, input logic [63:0] spv, input int stall,
                          input bit intrude, input string req);
    exp_t e;
    logic [31:0] w;
    logic [63:0] off, base, d, dd;
    bit wb, ov, bad, st;
    if (uns) w = {sz, 3'b111, 1'b0, 2'b01, 2'b00, imm, rn, rt};
    else     w = {sz, 3'b111, 1'b0, 2'b00, 2'b00, 1'b0, imm[8:0], pre, 1'b1, rn, rt};
    off  = uns ? ({52'b0, imm} << sz) : {{55{imm[8]}}, imm[8:0]};
    wb   = !uns;
    base = (rn == 5'd31) ? spv : regval(rn);
    ov   = wb && rn == rt && rn != 5'd31;
    bad  = rn == 5'd31 && spv[3:0] != 4'h0;
    st   = !bad && !(ov && pol[1]);
    e.req  = req;
    e.ill  = 0; e.flt = bad; e.trap = !bad && ov && pol == 2'b10;
    e.tag  = wb || rn != 5'd31;
    e.mem  = st;
    e.addr = (uns || pre) ? base + off : base;
    d      = (ov && pol == 2'b01) ? 64'h0 : regval(rt);
    dd     = (sz == 2'b11) ? d : {32'h0, d[31:0]};
    e.strb = ((sz == 2'b11) ? 8'hFF : 8'h0F) << e.addr[2:0];
    e.data = dd << (8 * e.addr[2:0]);
    e.size = sz;
    e.wrf  = st && wb && rn != 5'd31;
    e.wsp  = st && wb && rn == 5'd31;
    e.widx = rn;
    e.wval = base + off;
    run(w, e, pol, spv, stall, intrude);
  endtask

  task automatic do_bad(input logic [31:0] w, input string req);
    exp_t e;
    e.req = req; e.mem = 0; e.addr = 0; e.data = 0; e.strb = 0; e.size = 0;
    e.wrf = 0; e.wsp = 0; e.widx = 0; e.wval = 0;
    e.ill = 1; e.flt = 0; e.trap = 0; e.tag = 0;
    run(w, e, 2'b00, 64'h0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: idle after reset
    chk(!mem_req_valid && !done && !rf_we && !sp_we, "R11", "reset state",
        {60'b0, mem_req_valid, done, rf_we, sp_we}, 64'h0);

    do_store(0, 0, 2'b11, 12'h010, 5'd3, 5'd7, 2'b00, 0, 0, 0, "R2");
    do_store(0, 0, 2'b10, 12'h100, 5'd4, 5'd1, 2'b00, 0, 1, 0, "R2");
    do_store(0, 1, 2'b11, 12'h0FF, 5'd6, 5'd9, 2'b00, 0, 0, 0, "R3");
    do_store(0, 1, 2'b10, 12'h1FC, 5'd8, 5'd2, 2'b00, 0, 2, 0, "R3");
    do_store(1, 0, 2'b10, 12'hFFF, 5'd10, 5'd11, 2'b00, 0, 0, 0, "R4");
    do_store(1, 0, 2'b11, 12'hFFF, 5'd12, 5'd13, 2'b00, 0, 3, 0, "R10");
    do_store(0, 1, 2'b11, 12'h1F0, 5'd31, 5'd4, 2'b00, 64'h0000_7FFF_0000_1000, 0, 0, "R6");
    do_store(0, 0, 2'b10, 12'h020, 5'd31, 5'd5, 2'b00, 64'h0000_7FFF_0000_2000, 0, 0, "R6");
    do_store(1, 0, 2'b11, 12'h002, 5'd31, 5'd6, 2'b00, 64'h0000_7FFF_0000_3000, 0, 0, "R9");
    do_store(0, 1, 2'b11, 12'h008, 5'd31, 5'd4, 2'b00, 64'h0000_7FFF_0000_1008, 0, 0, "R7");
    do_store(1, 0, 2'b10, 12'h001, 5'd31, 5'd4, 2'b00, 64'h0000_7FFF_0000_1004, 0, 0, "R7");
    do_store(0, 0, 2'b11, 12'h008, 5'd5, 5'd5, 2'b00, 0, 0, 0, "R8");
    do_store(0, 1, 2'b11, 12'h008, 5'd5, 5'd5, 2'b01, 0, 0, 0, "R8");
    do_store(0, 1, 2'b10, 12'h004, 5'd5, 5'd5, 2'b10, 0, 0, 0, "R8");
    do_store(0, 0, 2'b11, 12'h008, 5'd5, 5'd5, 2'b11, 0, 0, 0, "R8");
    do_store(1, 0, 2'b11, 12'h003, 5'd5, 5'd5, 2'b10, 0, 0, 0, "R8");
    do_bad({2'b01, 3'b111, 1'b0, 2'b01, 2'b00, 12'd4, 5'd1, 5'd2}, "R1");
    do_bad({2'b11, 3'b111, 1'b1, 2'b01, 2'b00, 12'd4, 5'd1, 5'd2}, "R1");
    do_bad({2'b11, 3'b111, 1'b0, 2'b00, 2'b00, 1'b0, 9'd4, 2'b00, 5'd1, 5'd2}, "R1");
    do_bad({2'b10, 3'b111, 1'b0, 2'b00, 2'b00, 1'b1, 9'd4, 2'b11, 5'd1, 5'd2}, "R1");
    do_bad({2'b11, 3'b111, 1'b0, 2'b01, 2'b01, 12'd4, 5'd1, 5'd2}, "R1");
    do_store(0, 1, 2'b11, 12'h010, 5'd14, 5'd15, 2'b00, 0, 4, 1, "R12");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule